// File: doc/BRIEF.md
# Commit-Stage Squash Arbiter

This block sits in the commit stage of an out-of-order core and serves one hardware thread. Once per cycle it decides whether a pipeline squash starts and which sequence-number boundary goes with it. Three sources can ask for a squash. The first is a trap, which is raised a fixed number of cycles after it is taken. The second is an external context request that throws away the whole window. The third is an execute-stage squash, such as a branch mispredict, which carries its own sequence number and flags.

A trap or context squash discards everything. Its boundary is one below the reorder-buffer head, or zero when the buffer is empty, and it redirects fetch to the thread's saved commit PCs. An execute squash is checked for age against the youngest instruction the block knows about. Its boundary is then adjusted for the "squash the instruction itself" flag and, when delay slots are built in, for a kept delay slot. Every accepted squash sends a one-cycle pulse to earlier stages. The block then holds a squashing indication until the reorder buffer reports that the squash is finished.

Top module: `commit_squash_arb`

## Requirements
- R1: While reset is held, and on the first cycle after it, status is Running (code 0), every output is zero and the youngest sequence number is zero.
- R2: A trap taken while not in TrapWait moves status to TrapWait (code 2). Exactly TRAP_LAT cycles later, squash_o pulses and a squash-all is performed.
- R3: A squash-all (trap or context) outputs head_seq_i−1 as both done and ROB boundary, or 0 when rob_empty_i is high. It clears mispredict_o, redirects to commit_pc_i/commit_npc_i, and resets the youngest sequence number to 0.
- R4: While status is TrapWait, context squash and execute squash requests produce no pulse and are dropped.
- R5: An execute squash is accepted only when its sequence number is less than or equal to the youngest sequence number. Otherwise it is ignored.
- R6: With the include flag set, the done sequence number is ex_seq_i−1. After any accepted execute squash, the youngest sequence number becomes the done sequence number.
- R7: With DELAY_SLOT=1, the ROB boundary is ex_seq_i+1 when both mispredict and keep-slot are set, and the include flag's −1 is then applied to it. The done number never receives the +1.
- R8: An accepted squash sets status to Squashing (code 1) and pulses squash_o for one cycle. rob_squashing_o is high for as long as status is Squashing. Status returns to Running the cycle after rob_squash_done_i is seen.
- R9: insert_i loads insert_seq_i as the youngest sequence number only when status is not Squashing.
- R10: In a single cycle, a trap fire ranks above a context squash, which ranks above an execute squash, which ranks above a new trap. A lower-ranked request that loses is dropped.
- R11: An accepted execute squash outputs ex_next_pc_i, ex_next_npc_i and ex_mispredict_i on the redirect and mispredict outputs. mispredict_o is zero in every cycle without a squash pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_taken_i | input | 1 | A trap has been taken; start the latency timer |
| ctx_squash_i | input | 1 | External request to squash the whole thread |
| ex_squash_i | input | 1 | Execute-stage squash request |
| ex_seq_i | input | SEQ_W | Sequence number of the squashing instruction |
| ex_include_i | input | 1 | Also squash the squashing instruction |
| ex_mispredict_i | input | 1 | Squash comes from a branch mispredict |
| ex_keep_slot_i | input | 1 | Keep the branch delay slot |
| ex_next_pc_i | input | PC_W | Redirect PC from execute |
| ex_next_npc_i | input | PC_W | Redirect next PC from execute |
| commit_pc_i | input | PC_W | Saved commit PC of the thread |
| commit_npc_i | input | PC_W | Saved commit next PC of the thread |
| rob_empty_i | input | 1 | Reorder buffer holds nothing for this thread |
| head_seq_i | input | SEQ_W | Sequence number at the reorder-buffer head |
| insert_i | input | 1 | An instruction is being inserted |
| insert_seq_i | input | SEQ_W | Sequence number of the inserted instruction |
| rob_squash_done_i | input | 1 | Reorder buffer has finished squashing |
| squash_o | output | 1 | One-cycle squash pulse to earlier stages |
| rob_squashing_o | output | 1 | Squash still in progress |
| done_seq_o | output | SEQ_W | Youngest surviving sequence number |
| rob_bound_o | output | SEQ_W | Boundary handed to the reorder buffer |
| redirect_pc_o | output | PC_W | Fetch redirect PC |
| redirect_npc_o | output | PC_W | Fetch redirect next PC |
| mispredict_o | output | 1 | Squash is a branch mispredict |
| status_o | output | 2 | 0 Running, 1 Squashing, 2 TrapWait |

## Verification
A wrong youngest sequence number has no effect until the next execute squash arrives. At that point a request is accepted or dropped wrongly, and the error shows as a missing or extra squash_o pulse one cycle later. A timer that is off by one shows as a squash pulse one cycle early or late after a trap. A wrong status code shows at status_o on the very next cycle. The bench runs a behavioural model alongside the design and compares every output on every clock, so such faults are caught in the cycle where they first reach a port.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
   typedef enum logic [1:0] {
      ST_RUN       = 2'd0,
      ST_SQUASHING = 2'd1,
      ST_TRAP_WAIT = 2'd2
   } thr_state_e;
endpackage

// File: rtl/sqa_trap_timer.sv
module sqa_trap_timer #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic fire_o
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign fire_o = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(LAT - 1);
      end else if (fire_o) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R2: the arbiter never restarts a countdown that is already running
   p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q);
endmodule

// File: rtl/sqa_youngest.sv
module sqa_youngest #(
   parameter int SEQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             set_i,
   input  logic [SEQ_W-1:0] set_val_i,
   input  logic             ins_i,
   input  logic [SEQ_W-1:0] ins_seq_i,
   input  logic [SEQ_W-1:0] probe_seq_i,
   output logic             older_ok_o
);
   logic [SEQ_W-1:0] young_q;

   assign older_ok_o = (probe_seq_i <= young_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      young_q <= '0;
      else if (clr_i)  young_q <= '0;
      else if (set_i)  young_q <= set_val_i;
      else if (ins_i)  young_q <= ins_seq_i;
   end

   // R3: a squash-all leaves only sequence number zero as acceptable
   p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (young_q == '0));
endmodule

// File: rtl/sqa_boundary.sv
module sqa_boundary #(
   parameter int SEQ_W      = 16,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic [SEQ_W-1:0] seq_i,
   input  logic             include_i,
   input  logic             mispredict_i,
   input  logic             keep_slot_i,
   output logic [SEQ_W-1:0] done_seq_o,
   output logic [SEQ_W-1:0] rob_seq_o
);
   assign done_seq_o = seq_i - SEQ_W'(include_i);

   generate
      if (DELAY_SLOT) begin : g_slot
         assign rob_seq_o = seq_i + SEQ_W'(mispredict_i && keep_slot_i)
                                  - SEQ_W'(include_i);
      end else begin : g_noslot
         logic unused_slot;
         assign unused_slot = mispredict_i ^ keep_slot_i;
         assign rob_seq_o   = done_seq_o;
      end
   endgenerate
endmodule

// File: rtl/commit_squash_arb.sv
module commit_squash_arb
   import sqa_pkg::*;
#(
   parameter int SEQ_W      = 16,
   parameter int PC_W       = 32,
   parameter int TRAP_LAT   = 4,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_taken_i,
   input  logic             ctx_squash_i,
   input  logic             ex_squash_i,
   input  logic [SEQ_W-1:0] ex_seq_i,
   input  logic             ex_include_i,
   input  logic             ex_mispredict_i,
   input  logic             ex_keep_slot_i,
   input  logic [PC_W-1:0]  ex_next_pc_i,
   input  logic [PC_W-1:0]  ex_next_npc_i,
   input  logic [PC_W-1:0]  commit_pc_i,
   input  logic [PC_W-1:0]  commit_npc_i,
   input  logic             rob_empty_i,
   input  logic [SEQ_W-1:0] head_seq_i,
   input  logic             insert_i,
   input  logic [SEQ_W-1:0] insert_seq_i,
   input  logic             rob_squash_done_i,
   output logic             squash_o,
   output logic             rob_squashing_o,
   output logic [SEQ_W-1:0] done_seq_o,
   output logic [SEQ_W-1:0] rob_bound_o,
   output logic [PC_W-1:0]  redirect_pc_o,
   output logic [PC_W-1:0]  redirect_npc_o,
   output logic             mispredict_o,
   output logic [1:0]       status_o
);
   generate
      if (TRAP_LAT < 1) begin : g_bad_lat
         $error("TRAP_LAT must be at least 1");
      end
      if (SEQ_W < 2) begin : g_bad_seq
         $error("SEQ_W must be at least 2");
      end
   endgenerate

   thr_state_e       status_q, status_d;
   logic             trap_fire, older_ok;
   logic             can_take, take_all, take_ex, take_trap;
   logic [SEQ_W-1:0] all_seq, ex_done, ex_rob;
   logic             squash_q, mis_q;
   logic [SEQ_W-1:0] done_q, bound_q;
   logic [PC_W-1:0]  pc_q, npc_q;

   sqa_trap_timer #(.LAT(TRAP_LAT)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (take_trap),
      .fire_o  (trap_fire)
   );

   sqa_boundary #(.SEQ_W(SEQ_W), .DELAY_SLOT(DELAY_SLOT)) i_bound (
      .seq_i        (ex_seq_i),
      .include_i    (ex_include_i),
      .mispredict_i (ex_mispredict_i),
      .keep_slot_i  (ex_keep_slot_i),
      .done_seq_o   (ex_done),
      .rob_seq_o    (ex_rob)
   );

   sqa_youngest #(.SEQ_W(SEQ_W)) i_young (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (take_all),
      .set_i       (take_ex),
      .set_val_i   (ex_done),
      .ins_i       (insert_i && (status_q != ST_SQUASHING)),
      .ins_seq_i   (insert_seq_i),
      .probe_seq_i (ex_seq_i),
      .older_ok_o  (older_ok)
   );

   // priority: trap fire > context > execute > new trap
   assign can_take  = (status_q != ST_TRAP_WAIT);
   assign take_all  = trap_fire || (ctx_squash_i && can_take);
   assign take_ex   = !take_all && ex_squash_i && can_take && older_ok;
   assign take_trap = !take_all && !take_ex && trap_taken_i && can_take;
   assign all_seq   = rob_empty_i ? '0 : head_seq_i - 1'b1;

   always_comb begin
      status_d = status_q;
      if (take_all || take_ex)
         status_d = ST_SQUASHING;
      else if (take_trap)
         status_d = ST_TRAP_WAIT;
      else if (status_q == ST_SQUASHING && rob_squash_done_i)
         status_d = ST_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= ST_RUN;
         squash_q <= 1'b0;
         mis_q    <= 1'b0;
         done_q   <= '0;
         bound_q  <= '0;
         pc_q     <= '0;
         npc_q    <= '0;
      end else begin
         status_q <= status_d;
         squash_q <= take_all || take_ex;
         mis_q    <= take_ex && ex_mispredict_i;
         if (take_all) begin
            done_q  <= all_seq;
            bound_q <= all_seq;
            pc_q    <= commit_pc_i;
            npc_q   <= commit_npc_i;
         end else if (take_ex) begin
            done_q  <= ex_done;
            bound_q <= ex_rob;
            pc_q    <= ex_next_pc_i;
            npc_q   <= ex_next_npc_i;
         end
      end
   end

   assign squash_o        = squash_q;
   assign rob_squashing_o = (status_q == ST_SQUASHING);
   assign done_seq_o      = done_q;
   assign rob_bound_o     = bound_q;
   assign redirect_pc_o   = pc_q;
   assign redirect_npc_o  = npc_q;
   assign mispredict_o    = mis_q;
   assign status_o        = status_q;

   // R8: a squash pulse is always accompanied by the squashing status
   p_pulse_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_q |-> (status_q == ST_SQUASHING));

   // R4: while waiting on a trap nothing but the timer can squash
   p_trap_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == ST_TRAP_WAIT && !trap_fire) |=> !squash_q);

   // R3: a trap squash is a squash-all, never a mispredict
   p_trap_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_fire |=> (squash_q && !mis_q && pc_q == $past(commit_pc_i)));

   // R8: a finished squash with no new request releases to running
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == ST_SQUASHING && rob_squash_done_i && !ctx_squash_i
       && !ex_squash_i && !trap_taken_i) |=> (status_q == ST_RUN));
endmodule

// File: tb/test_commit_squash_arb.sv
module test_commit_squash_arb;
   localparam int SW  = 16;
   localparam int PW  = 32;
   localparam int LAT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trap_taken, ctx_sq, ex_sq, ex_inc, ex_mis, ex_keep, rob_empty;
   logic ins, rdone;
   logic [SW-1:0] ex_seq, head_seq, ins_seq;
   logic [PW-1:0] ex_pc, ex_npc, c_pc, c_npc;
   logic squash, robsq, mis;
   logic [SW-1:0] done_seq, bound;
   logic [PW-1:0] rpc, rnpc;
   logic [1:0] status;

   always #10 clk = ~clk;

   commit_squash_arb #(.SEQ_W(SW), .PC_W(PW), .TRAP_LAT(LAT), .DELAY_SLOT(1'b1)) i_commit_squash_arb (
      .clk(clk), .rst_n(rst_n), .trap_taken_i(trap_taken), .ctx_squash_i(ctx_sq),
      .ex_squash_i(ex_sq), .ex_seq_i(ex_seq), .ex_include_i(ex_inc),
      .ex_mispredict_i(ex_mis), .ex_keep_slot_i(ex_keep), .ex_next_pc_i(ex_pc),
      .ex_next_npc_i(ex_npc), .commit_pc_i(c_pc), .commit_npc_i(c_npc),
      .rob_empty_i(rob_empty), .head_seq_i(head_seq), .insert_i(ins),
      .insert_seq_i(ins_seq), .rob_squash_done_i(rdone), .squash_o(squash),
      .rob_squashing_o(robsq), .done_seq_o(done_seq), .rob_bound_o(bound),
      .redirect_pc_o(rpc), .redirect_npc_o(rnpc), .mispredict_o(mis),
      .status_o(status));

   int n_chk = 0, n_err = 0;
   string tag = "R1";
   bit finished = 1'b0;

   // behavioural reference
   int m_st, m_cnt;
   logic [SW-1:0] m_young, m_done, m_bound;
   logic [PW-1:0] m_pc, m_npc;
   bit m_sq, m_mis;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_young = '0; m_done = '0; m_bound = '0;
         m_pc = '0; m_npc = '0; m_sq = 0; m_mis = 0;
      end else begin
         bit fire, ok;
         int old_st;
         old_st = m_st;
         fire = (m_st == 2) && (m_cnt == 0);
         ok = (m_st != 2);
         if (fire || (ctx_sq && ok)) begin
            m_done = rob_empty ? '0 : head_seq - 1'b1;
            m_bound = m_done; m_pc = c_pc; m_npc = c_npc;
            m_sq = 1; m_mis = 0; m_young = '0; m_st = 1;
         end else if (ex_sq && ok && (ex_seq <= m_young)) begin
            m_done = ex_seq - SW'(ex_inc);
            m_bound = ex_seq + SW'(ex_mis && ex_keep) - SW'(ex_inc);
            m_pc = ex_pc; m_npc = ex_npc; m_sq = 1; m_mis = ex_mis;
            m_young = m_done; m_st = 1;
         end else begin
            m_sq = 0; m_mis = 0;
            if (trap_taken && ok) begin m_st = 2; m_cnt = LAT - 1; end
            else if (m_st == 1 && rdone) m_st = 0;
            else if (m_st == 2) m_cnt = m_cnt - 1;
            if (ins && old_st != 1) m_young = ins_seq;
         end
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag, "squash_o", squash, m_sq);
         chk(tag, "rob_squashing_o", robsq, m_st == 1);
         chk(tag, "status_o", status, m_st);
         chk(tag, "done_seq_o", done_seq, m_done);
         chk(tag, "rob_bound_o", bound, m_bound);
         chk(tag, "redirect_pc_o", rpc, m_pc);
         chk(tag, "redirect_npc_o", rnpc, m_npc);
         chk(tag, "mispredict_o", mis, m_mis);
      end
   end

   task automatic idle();
      trap_taken = 0; ctx_sq = 0; ex_sq = 0; ex_inc = 0; ex_mis = 0; ex_keep = 0;
      ins = 0; rdone = 0;
   endtask

   task automatic ex(logic [SW-1:0] s, bit inc, bit mp, bit keep);
      ex_sq = 1; ex_seq = s; ex_inc = inc; ex_mis = mp; ex_keep = keep;
      @(negedge clk); idle();
   endtask

   task automatic release_sq();
      rdone = 1; @(negedge clk); idle();
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #(20ns * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      idle();
      rob_empty = 0; head_seq = '0; ex_seq = '0; ins_seq = '0;
      ex_pc = 32'h1000; ex_npc = 32'h1004; c_pc = 32'h2000; c_npc = 32'h2004;
      repeat (3) @(negedge clk);
      tag = "R1";
      chk("R1", "reset status", status, 0);
      chk("R1", "reset squash", squash, 0);
      chk("R1", "reset done", done_seq, 0);
      rst_n = 1;
      @(negedge clk);

      tag = "R9";
      for (int i = 1; i <= 10; i++) begin ins = 1; ins_seq = SW'(i); @(negedge clk); end
      idle();

      tag = "R5";
      ex(16'd12, 0, 0, 0);
      chk("R5", "too young dropped", squash, 0);

      tag = "R7";
      ex(16'd8, 0, 1, 1);
      chk("R7", "done no +1", done_seq, 8);
      chk("R7", "rob bound +1", bound, 9);
      chk("R11", "mispredict", mis, 1);
      chk("R11", "redirect pc", rpc, 32'h1000);
      tag = "R8";
      @(negedge clk);
      chk("R8", "one-cycle pulse", squash, 0);
      chk("R8", "still squashing", robsq, 1);
      tag = "R9";
      ins = 1; ins_seq = 16'd20; @(negedge clk); idle();
      tag = "R8";
      release_sq();
      chk("R8", "back to running", status, 0);
      tag = "R9";
      ex(16'd9, 0, 0, 0);
      chk("R9", "insert during squash ignored", squash, 0);

      tag = "R6";
      ex(16'd8, 1, 1, 0);
      chk("R6", "include done", done_seq, 7);
      chk("R6", "include bound", bound, 7);
      release_sq();
      ex(16'd8, 0, 0, 0);
      chk("R6", "youngest lowered", squash, 0);
      ex(16'd7, 1, 1, 1);
      chk("R7", "keep+include bound", bound, 7);
      chk("R6", "include done 6", done_seq, 6);
      release_sq();

      tag = "R3";
      head_seq = 16'd5; ctx_sq = 1; @(negedge clk); idle();
      chk("R3", "squash-all done", done_seq, 4);
      chk("R3", "redirect commit pc", rpc, 32'h2000);
      chk("R3", "no mispredict", mis, 0);
      release_sq();
      rob_empty = 1; ctx_sq = 1; @(negedge clk); idle();
      chk("R3", "empty rob boundary", done_seq, 0);
      release_sq();
      rob_empty = 0;

      tag = "R2";
      ins = 1; ins_seq = 16'd30; @(negedge clk); idle();
      head_seq = 16'd12;
      trap_taken = 1; @(negedge clk); idle();
      chk("R2", "trap wait status", status, 2);
      for (int k = 1; k <= LAT; k++) begin
         if (k == 1) begin tag = "R4"; ctx_sq = 1; ex_sq = 1; ex_seq = 16'd30; end
         @(negedge clk); idle();
         if (k < LAT) chk(k == 1 ? "R4" : "R2", "no early squash", squash, 0);
         else begin
            chk("R2", "trap fires at latency", squash, 1);
            chk("R2", "trap boundary", done_seq, 11);
         end
      end
      tag = "R2";
      release_sq();

      tag = "R10";
      ins = 1; ins_seq = 16'd40; @(negedge clk); idle();
      ctx_sq = 1; ex(16'd40, 0, 1, 0);
      chk("R10", "context beats execute", mis, 0);
      chk("R10", "context boundary", done_seq, 11);
      release_sq();
      ins = 1; ins_seq = 16'd50; @(negedge clk); idle();
      trap_taken = 1; ex(16'd50, 0, 1, 0);
      chk("R10", "execute beats new trap", status, 1);
      release_sq();
      repeat (LAT + 2) @(negedge clk);
      chk("R10", "dropped trap never fires", status, 0);

      summary();
   end
endmodule